// File: doc/BRIEF.md
# Privilege-Gated Status Word Update Filter

This block holds the processor status word and decides, field by field, how much of a proposed new value may be taken in. Three operations reach it: a restore of the status word from the stack (pop), a restore during interrupt return (return), and a save of the status word to the stack (push). Each update is gated by the current privilege level and by whether the machine runs with protection enabled. It is judged against the I/O privilege field held in the status word before the write.

When a protected field may not change, it keeps its old value. No exception and no status indication is raised. Ordinary condition and control bits follow the proposed value. The reserved bits are held at their fixed values. On a push, the block loads a save register with the current status word, with the virtual-mode bit cleared.

Top module: `flg_write_filter`

## Requirements
- R1: A synchronous active-high reset sets both the status word and the save value to 0x00000002.
- R2: The I/O privilege field, bits 13:12, is written only when the effective privilege is 0. Otherwise the field keeps its old value.
- R3: The interrupt-enable bit, bit 9, is written only when the effective privilege is less than or equal to the I/O privilege field held before the write. Otherwise the bit keeps its old value.
- R4: The virtual-mode bit, bit 17, is written only by a return at effective privilege 0. A pop never changes it.
- R5: A push leaves the status word unchanged and loads the save value with the status word of the preceding cycle, with bit 17 forced to 0.
- R6: Bit 1 always reads 1. Bits 3, 5 and 15 always read 0, and so do bits 31:18.
- R7: On a pop or a return, bits 0, 2, 4, 6, 7, 8, 10, 11, 14 and 16 take the proposed value without restriction.
- R8: The operation code is 00 for pop, 01 for return and 10 for push. Code 11, and any cycle with the write strobe low, changes neither output.
- R9: With protection disabled, the effective privilege is 0, whatever value the privilege input has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the operation on `op` |
| op | input | 2 | Operation code: 00 pop, 01 return, 10 push, 11 none |
| cur_priv | input | 2 | Current privilege level (0 is the most privileged) |
| prot_en | input | 1 | Protection enabled |
| new_flags | input | 32 | Proposed status word |
| flags_q | output | 32 | Committed status word |
| push_val | output | 32 | Value saved by the last push |

## Verification
The bench builds the block with its default 32-bit word. This width puts every gated field at its real bit position: bit 9, bits 13:12 and bit 17. It also exposes the reserved positions, including the undefined upper bits 31:18.

The stimulus first raises the I/O privilege field to a non-zero level. Privilege comparisons then fall on both sides of the boundary: equal levels are allowed, and a higher level is refused. The virtual-mode bit is driven through pops and returns at several privilege levels. Unprotected writes, the spare operation code and a reset in mid-run are also covered.

// File: rtl/flg_pkg.sv
package flg_pkg;
  parameter int FLAG_W = 32;

  localparam int IF_BIT   = 9;
  localparam int IOPL_LO  = 12;
  localparam int IOPL_HI  = 13;
  localparam int VM_BIT   = 17;

  localparam logic [FLAG_W-1:0] IF_MASK   = FLAG_W'(1) << IF_BIT;
  localparam logic [FLAG_W-1:0] IOPL_MASK = FLAG_W'(3) << IOPL_LO;
  localparam logic [FLAG_W-1:0] VM_MASK   = FLAG_W'(1) << VM_BIT;
  localparam logic [FLAG_W-1:0] ONE_MASK  = FLAG_W'(32'h0000_0002);
  localparam logic [FLAG_W-1:0] FREE_MASK = FLAG_W'(32'h0001_4DD5);
  localparam logic [FLAG_W-1:0] RESET_VAL = ONE_MASK;

  typedef enum logic [1:0] {
    OP_POP  = 2'b00,
    OP_RET  = 2'b01,
    OP_PUSH = 2'b10,
    OP_NONE = 2'b11
  } fop_t;
endpackage

// File: rtl/flg_perm.sv
module flg_perm
  import flg_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [1:0]        cur_priv,
  input  logic              prot_en,
  input  logic [1:0]        old_iopl,
  output logic [FLAG_W-1:0] allow
);
  logic [1:0] eff_priv;
  logic       lvl0, io_ok, if_ok, vm_ok, is_wr;
  fop_t       opc;

  always_comb begin
    opc      = fop_t'(op);
    eff_priv = prot_en ? cur_priv : 2'd0;
    lvl0     = (eff_priv == 2'd0);
    is_wr    = (opc == OP_POP) || (opc == OP_RET);
    io_ok    = is_wr && lvl0;
    if_ok    = is_wr && (eff_priv <= old_iopl);
    vm_ok    = (opc == OP_RET) && lvl0;
    allow    = '0;
    if (is_wr) allow = FREE_MASK;
    if (io_ok) allow = allow | IOPL_MASK;
    if (if_ok) allow = allow | IF_MASK;
    if (vm_ok) allow = allow | VM_MASK;
  end
endmodule

// File: rtl/flg_merge.sv
module flg_merge
  import flg_pkg::*;
(
  input  logic [FLAG_W-1:0] old_flags,
  input  logic [FLAG_W-1:0] new_flags,
  input  logic [FLAG_W-1:0] allow,
  output logic [FLAG_W-1:0] merged
);
  localparam logic [FLAG_W-1:0] DEF_MASK = FREE_MASK | IF_MASK | IOPL_MASK | VM_MASK;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (ONE_MASK[i]) begin : g_one
      assign merged[i] = 1'b1;
    end else if (DEF_MASK[i]) begin : g_def
      assign merged[i] = allow[i] ? new_flags[i] : old_flags[i];
    end else begin : g_zero
      assign merged[i] = 1'b0;
    end
  end
endmodule

// File: rtl/flg_write_filter.sv
module flg_write_filter
  import flg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        op,
  input  logic [1:0]        cur_priv,
  input  logic              prot_en,
  input  logic [31:0]       new_flags,
  output logic [31:0]       flags_q,
  output logic [31:0]       push_val
);
  logic [FLAG_W-1:0] allow;
  logic [FLAG_W-1:0] merged;
  logic              upd;
  logic              do_push;

  flg_perm u_perm (
    .op       (op),
    .cur_priv (cur_priv),
    .prot_en  (prot_en),
    .old_iopl (flags_q[IOPL_HI:IOPL_LO]),
    .allow    (allow)
  );

  flg_merge u_merge (
    .old_flags (flags_q),
    .new_flags (new_flags),
    .allow     (allow),
    .merged    (merged)
  );

  assign upd     = wr_en && ((op == OP_POP) || (op == OP_RET));
  assign do_push = wr_en && (op == OP_PUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= RESET_VAL;
      push_val <= RESET_VAL;
    end else begin
      if (upd)     flags_q  <= merged;
      if (do_push) push_val <= flags_q & ~VM_MASK;
    end
  end

  AST_IOPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && prot_en && cur_priv != 2'd0) |=> (flags_q[13:12] == $past(flags_q[13:12]))); // R2
  AST_IF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && prot_en && cur_priv > flags_q[13:12]) |=> (flags_q[9] == $past(flags_q[9]))); // R3
  AST_VM_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == 2'b00) |=> (flags_q[17] == $past(flags_q[17]))); // R4
  AST_PUSH_SAVE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == 2'b10) |=> (push_val == ($past(flags_q) & 32'hFFFD_FFFF)) && $stable(flags_q)); // R5
  AST_RSVD_FIXED: assert property (@(posedge clk) disable iff (rst)
    (flags_q[1] && !flags_q[3] && !flags_q[5] && !flags_q[15] && flags_q[31:18] == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || op == 2'b11) |=> ($stable(flags_q) && $stable(push_val))); // R8
endmodule

// File: tb/flg_write_filter_tb.sv
module flg_write_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  op = 2'b11;
  logic [1:0]  cur_priv = 2'd0;
  logic        prot_en = 1'b1;
  logic [31:0] new_flags = '0;
  logic [31:0] flags_q, push_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] f;
    logic [31:0] p;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_flags = 32'h2;
  logic [31:0] m_push  = 32'h2;

  always #10 clk = ~clk;

  flg_write_filter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op(op), .cur_priv(cur_priv),
    .prot_en(prot_en), .new_flags(new_flags), .flags_q(flags_q), .push_val(push_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input bit we, input logic [1:0] o, input logic [1:0] pr,
                       input bit pe, input logic [31:0] nv);
    logic [1:0]  lvl;
    logic [31:0] n;
    lvl = pe ? pr : 2'd0;
    if (!we || o == 2'b11) return;
    if (o == 2'b10) begin
      m_push = m_flags;
      m_push[17] = 1'b0;
      return;
    end
    n = 32'h2;
    foreach (n[i]) if (i inside {0,2,4,6,7,8,10,11,14,16}) n[i] = nv[i];
    n[13:12] = (lvl == 0) ? nv[13:12] : m_flags[13:12];
    n[9]     = (lvl <= m_flags[13:12]) ? nv[9] : m_flags[9];
    n[17]    = (o == 2'b01 && lvl == 0) ? nv[17] : m_flags[17];
    m_flags = n;
  endtask

  task automatic drive(input string tag, input bit we, input logic [1:0] o,
                       input logic [1:0] pr, input bit pe, input logic [31:0] nv);
    exp_t e;
    @(negedge clk);
    wr_en = we; op = o; cur_priv = pr; prot_en = pe; new_flags = nv;
    model(we, o, pr, pe, nv);
    e.f = m_flags; e.p = m_push; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " flags"}, flags_q, e.f);
        chk({e.tag, " push"},  push_val, e.p);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset flags", flags_q, 32'h2);
    chk("R1 reset push", push_val, 32'h2);
    drive("R7 R6 pop all ones lvl0", 1, 2'b00, 2'd0, 1, 32'hFFFF_FFFF);
    drive("R4 return sets vm lvl0", 1, 2'b01, 2'd0, 1, 32'h0002_0000);
    drive("R7 pop restore lvl0", 1, 2'b00, 2'd0, 1, 32'h0000_32C5);
    drive("R5 push clears vm", 1, 2'b10, 2'd3, 1, 32'hFFFF_FFFF);
    drive("R2 R3 pop lvl3 eq iopl", 1, 2'b00, 2'd3, 1, 32'h0000_0000);
    drive("R2 pop lvl0 iopl1 if1", 1, 2'b00, 2'd0, 1, 32'h0000_1201);
    drive("R3 pop lvl2 above iopl", 1, 2'b00, 2'd2, 1, 32'h0000_30D4);
    drive("R4 return lvl1 vm kept", 1, 2'b01, 2'd1, 1, 32'h0000_0000);
    drive("R4 pop lvl0 vm kept", 1, 2'b00, 2'd0, 1, 32'h0000_0200);
    drive("R8 strobe low", 0, 2'b00, 2'd0, 1, 32'hFFFF_FFFF);
    drive("R8 op code 11", 1, 2'b11, 2'd0, 1, 32'hFFFF_FFFF);
    drive("R9 unprotected lvl3", 1, 2'b00, 2'd3, 0, 32'h0000_3200);
    drive("R9 R4 unprotected return", 1, 2'b01, 2'd3, 0, 32'h0000_0001);
    drive("R5 push no vm", 1, 2'b10, 2'd0, 1, 32'h0);
    drive("R6 pop reserved ones", 1, 2'b00, 2'd0, 1, 32'hFFFC_802A);
    drive("R8 idle", 0, 2'b10, 2'd0, 1, 32'h0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset flags", flags_q, 32'h2);
    chk("R1 mid reset push", push_val, 32'h2);
    m_flags = 32'h2;
    m_push  = 32'h2;
    drive("R3 after reset lvl1 iopl0", 1, 2'b00, 2'd1, 1, 32'h0000_0201);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule